// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Acceptance Controller

This block decides when a small CPU takes a maskable interrupt, and then runs the entry and exit of the handler. Each source has three flags. The request flag is set by a one-cycle pulse from the source. The mask flag and the one-bit priority flag are written by the CPU. At every instruction-boundary strobe the block picks a winner among the pending, unmasked sources. It then checks that winner against the global enable and against an in-service priority bit. An accepted source gets a one-hot acknowledge pulse, which also clears its request flag.

After acceptance a fixed sequence runs. The status word is pushed to the stack, followed by the saved program counter. The global enable is then cleared, and the winner's priority flag is copied into the in-service bit. Last, the program counter is loaded from the source's vector entry. A return-from-interrupt strobe reverses this. It pops the program counter, which is loaded at once, and then pops the status word, which restores both the enable and the in-service bit.

Priority flag value 0 means high priority and 1 means low. An in-service bit of 0 means a high-priority handler is running. In that state low-priority sources are held back even when the enable is set again inside the handler.

Top module: `irq_accept_ctrl`

## Requirements
- R1: A source is a candidate only when its request flag is 1 and its mask flag is 0; a masked source is never acknowledged.
- R2: Acceptance is evaluated only in a cycle where `boundary_i` is 1, the block is idle and the global enable `ie_o` is 1.
- R3: While `isp_o` is 0, sources whose priority flag is 1 are not accepted, while sources whose priority flag is 0 still are.
- R4: Among eligible candidates, priority flag 0 beats priority flag 1, and within equal priority the lower source index wins; `ack_o` is one-hot or zero.
- R5: In the cycle after the accepting boundary, `ack_o` pulses for the winner. The status word is then pushed on `stack_wdata_o`, with bit 0 holding the enable, bit 1 the in-service bit and all other bits 0. Next the `pc_i` value sampled in the accepting cycle is pushed. Afterwards `ie_o` is 0 and `isp_o` equals the winner's priority flag.
- R6: Two cycles after the program counter push, `pc_load_o` pulses with `pc_load_addr_o = VEC_BASE + index * VEC_STRIDE`. For low-priority winners one extra idle cycle comes between the acknowledge and the status push.
- R7: A request that cannot be accepted stays pending and is accepted at the first boundary at which the enable, mask and priority conditions allow it.
- R8: Counting both the request cycle and the load cycle, the request-to-vector-load latency is 7 cycles for a high-priority source and 8 for a low-priority one when the boundary comes the cycle after the request. It is 32 and 33 when the boundary comes 25 cycles later.
- R9: A return strobe pops twice on `stack_re_o`, with read data valid in the same cycle. The first word is loaded through `pc_load_o` and `pc_load_addr_o`. The second word restores `ie_o` from bit 0 and `isp_o` from bit 1.
- R10: The accepted source's request flag is cleared in the acknowledge cycle, unless a new pulse from that source arrives in the same cycle, in which case it stays set.
- R11: When idle, a return strobe takes precedence over a boundary in the same cycle; both strobes are ignored while `busy_o` is 1.
- R12: After reset `ie_o` is 0, `isp_o` is 1, all masks are 1, all priority flags are 1 and no request is pending. Mask, priority and enable writes take effect in the next cycle, but the sequence's own enable updates win over a same-cycle enable write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_SRC | Request pulses, one per source |
| mask_we_i | input | 1 | Mask flag write strobe |
| mask_wdata_i | input | N_SRC | New mask flags |
| prio_we_i | input | 1 | Priority flag write strobe |
| prio_wdata_i | input | N_SRC | New priority flags (0 = high) |
| ie_we_i | input | 1 | Global enable write strobe |
| ie_wdata_i | input | 1 | New global enable value |
| boundary_i | input | 1 | Instruction-boundary strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| pc_i | input | PC_W | Return address at the boundary |
| stack_rdata_i | input | PC_W | Stack top word, valid while popping |
| ack_o | output | N_SRC | One-hot acknowledge of the accepted source |
| stack_we_o | output | 1 | Stack push request |
| stack_re_o | output | 1 | Stack pop request |
| stack_wdata_o | output | PC_W | Word to push |
| pc_load_o | output | 1 | Program counter load strobe |
| pc_load_addr_o | output | PC_W | Vector or popped return address |
| ie_o | output | 1 | Global interrupt enable |
| isp_o | output | 1 | In-service priority bit (0 = high-priority handler running) |
| busy_o | output | 1 | Entry or exit sequence in progress |

## Verification
The arbitration is tried with several request patterns. A masked source shows that masking gates candidacy. A pending request held while the enable is low shows that requests persist. A mixed-priority pair shows that the priority flag outranks index order, and a same-priority pair shows that index order decides ties. Nested entry checks that the in-service bit blocks a low source while a high one still gets in, and that each return restores the pushed state. Latency is measured for both priority levels, with a boundary in the next cycle and with one delayed by 25 cycles, which separates the extra low-priority slot from boundary gating. Collision cases check a re-request inside the acknowledge cycle and a return strobe arriving together with a boundary.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEL,
    ST_LDLY,
    ST_PSW,
    ST_PC,
    ST_VRD,
    ST_VLD,
    ST_POP_PC,
    ST_POP_PSW
  } seq_state_e;

  // status word layout, decoded again on return
  localparam int unsigned PSW_IE_BIT  = 0;
  localparam int unsigned PSW_ISP_BIT = 1;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] ack_i,
  input  logic             mask_we_i,
  input  logic [N_SRC-1:0] mask_wdata_i,
  input  logic             prio_we_i,
  input  logic [N_SRC-1:0] prio_wdata_i,
  output logic [N_SRC-1:0] req_o,
  output logic [N_SRC-1:0] mask_o,
  output logic [N_SRC-1:0] prio_o
);
  logic [N_SRC-1:0] req_q;
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] prio_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    // a fresh pulse beats the acknowledge clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        req_q[g] <= 1'b0;
      end else if (req_i[g]) begin
        req_q[g] <= 1'b1;
      end else if (ack_i[g]) begin
        req_q[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      prio_q <= '1;
    end else begin
      if (mask_we_i) mask_q <= mask_wdata_i;
      if (prio_we_i) prio_q <= prio_wdata_i;
    end
  end

  assign req_o  = req_q;
  assign mask_o = mask_q;
  assign prio_o = prio_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] mask_i,
  input  logic [N_SRC-1:0] prio_i,
  input  logic             isp_i,
  output logic             win_valid_o,
  output logic [IDX_W-1:0] win_idx_o,
  output logic             win_prio_o
);
  logic [N_SRC-1:0] cand;
  logic [N_SRC-1:0] elig;
  logic [N_SRC-1:0] hi_set;
  logic [N_SRC-1:0] lo_set;
  logic [N_SRC-1:0] pick;

  assign cand   = req_i & ~mask_i;
  assign elig   = isp_i ? cand : (cand & ~prio_i);
  assign hi_set = elig & ~prio_i;
  assign lo_set = elig & prio_i;
  assign pick   = (|hi_set) ? hi_set : lo_set;

  always_comb begin
    win_idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pick[i]) win_idx_o = IDX_W'(i);
    end
  end

  assign win_valid_o = |pick;
  assign win_prio_o  = ~(|hi_set);
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC      = 8,
  parameter int unsigned PC_W       = 16,
  parameter logic [PC_W-1:0] VEC_BASE = 'h40,
  parameter int unsigned VEC_STRIDE = 4,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             boundary_i,
  input  logic             reti_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             ie_we_i,
  input  logic             ie_wdata_i,
  input  logic             win_valid_i,
  input  logic [IDX_W-1:0] win_idx_i,
  input  logic             win_prio_i,
  input  logic [PC_W-1:0]  stack_rdata_i,
  output logic [N_SRC-1:0] ack_o,
  output logic             stack_we_o,
  output logic             stack_re_o,
  output logic [PC_W-1:0]  stack_wdata_o,
  output logic             pc_load_o,
  output logic [PC_W-1:0]  pc_load_addr_o,
  output logic             ie_o,
  output logic             isp_o,
  output logic             busy_o
);
  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic             sel_prio_q;
  logic [PC_W-1:0]  pc_q;
  logic [PC_W-1:0]  vec_q;
  logic             ie_q;
  logic             isp_q;
  logic             accept;
  logic [PC_W-1:0]  psw_w;
  logic [PC_W-1:0]  vec_w;

  assign accept = boundary_i & ie_q & win_valid_i & ~reti_i;
  assign vec_w  = VEC_BASE + PC_W'(idx_q) * PC_W'(VEC_STRIDE);

  always_comb begin
    psw_w              = '0;
    psw_w[PSW_IE_BIT]  = ie_q;
    psw_w[PSW_ISP_BIT] = isp_q;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (reti_i)      state_d = ST_POP_PC;
        else if (accept) state_d = ST_SEL;
      end
      ST_SEL:     state_d = sel_prio_q ? ST_LDLY : ST_PSW;
      ST_LDLY:    state_d = ST_PSW;
      ST_PSW:     state_d = ST_PC;
      ST_PC:      state_d = ST_VRD;
      ST_VRD:     state_d = ST_VLD;
      ST_VLD:     state_d = ST_IDLE;
      ST_POP_PC:  state_d = ST_POP_PSW;
      ST_POP_PSW: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      sel_prio_q <= 1'b0;
      pc_q       <= '0;
      vec_q      <= '0;
      ie_q       <= 1'b0;
      isp_q      <= 1'b1;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && accept) begin
        idx_q      <= win_idx_i;
        sel_prio_q <= win_prio_i;
        pc_q       <= pc_i;
      end
      if (state_q == ST_VRD) vec_q <= vec_w;
      if (state_q == ST_PC) begin
        ie_q  <= 1'b0;
        isp_q <= sel_prio_q;
      end else if (state_q == ST_POP_PSW) begin
        ie_q  <= stack_rdata_i[PSW_IE_BIT];
        isp_q <= stack_rdata_i[PSW_ISP_BIT];
      end else if (ie_we_i) begin
        ie_q <= ie_wdata_i;
      end
    end
  end

  assign ack_o      = (state_q == ST_SEL) ? (N_SRC'(1) << idx_q) : '0;
  assign stack_we_o = (state_q == ST_PSW) || (state_q == ST_PC);
  assign stack_re_o = (state_q == ST_POP_PC) || (state_q == ST_POP_PSW);
  assign pc_load_o  = (state_q == ST_VLD) || (state_q == ST_POP_PC);

  always_comb begin
    stack_wdata_o = '0;
    if (state_q == ST_PSW)     stack_wdata_o = psw_w;
    else if (state_q == ST_PC) stack_wdata_o = pc_q;
  end

  always_comb begin
    pc_load_addr_o = '0;
    if (state_q == ST_VLD)         pc_load_addr_o = vec_q;
    else if (state_q == ST_POP_PC) pc_load_addr_o = stack_rdata_i;
  end

  assign ie_o   = ie_q;
  assign isp_o  = isp_q;
  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl #(
  parameter int unsigned N_SRC      = 8,
  parameter int unsigned PC_W       = 16,
  parameter logic [PC_W-1:0] VEC_BASE = 'h40,
  parameter int unsigned VEC_STRIDE = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic             mask_we_i,
  input  logic [N_SRC-1:0] mask_wdata_i,
  input  logic             prio_we_i,
  input  logic [N_SRC-1:0] prio_wdata_i,
  input  logic             ie_we_i,
  input  logic             ie_wdata_i,
  input  logic             boundary_i,
  input  logic             reti_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PC_W-1:0]  stack_rdata_i,
  output logic [N_SRC-1:0] ack_o,
  output logic             stack_we_o,
  output logic             stack_re_o,
  output logic [PC_W-1:0]  stack_wdata_o,
  output logic             pc_load_o,
  output logic [PC_W-1:0]  pc_load_addr_o,
  output logic             ie_o,
  output logic             isp_o,
  output logic             busy_o
);
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0] req_q;
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] prio_q;
  logic             win_valid;
  logic [IDX_W-1:0] win_idx;
  logic             win_prio;

  irq_flag_bank #(.N_SRC(N_SRC)) u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .ack_i        (ack_o),
    .mask_we_i    (mask_we_i),
    .mask_wdata_i (mask_wdata_i),
    .prio_we_i    (prio_we_i),
    .prio_wdata_i (prio_wdata_i),
    .req_o        (req_q),
    .mask_o       (mask_q),
    .prio_o       (prio_q)
  );

  irq_arbiter #(.N_SRC(N_SRC)) u_arb (
    .req_i       (req_q),
    .mask_i      (mask_q),
    .prio_i      (prio_q),
    .isp_i       (isp_o),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx),
    .win_prio_o  (win_prio)
  );

  irq_seq #(
    .N_SRC      (N_SRC),
    .PC_W       (PC_W),
    .VEC_BASE   (VEC_BASE),
    .VEC_STRIDE (VEC_STRIDE)
  ) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .boundary_i     (boundary_i),
    .reti_i         (reti_i),
    .pc_i           (pc_i),
    .ie_we_i        (ie_we_i),
    .ie_wdata_i     (ie_wdata_i),
    .win_valid_i    (win_valid),
    .win_idx_i      (win_idx),
    .win_prio_i     (win_prio),
    .stack_rdata_i  (stack_rdata_i),
    .ack_o          (ack_o),
    .stack_we_o     (stack_we_o),
    .stack_re_o     (stack_re_o),
    .stack_wdata_o  (stack_wdata_o),
    .pc_load_o      (pc_load_o),
    .pc_load_addr_o (pc_load_addr_o),
    .ie_o           (ie_o),
    .isp_o          (isp_o),
    .busy_o         (busy_o)
  );
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
  parameter int unsigned N_SRC = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             boundary_i,
  input logic [N_SRC-1:0] ack_i,
  input logic             stack_we_i,
  input logic             stack_re_i,
  input logic             pc_load_i,
  input logic             ie_i,
  input logic             isp_i,
  input logic [N_SRC-1:0] mask_i,
  input logic [N_SRC-1:0] prio_i
);
  assert_ack_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_i));

  assert_ack_after_enabled_boundary_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ack_i) |-> ($past(ie_i) && $past(boundary_i)));

  assert_ack_unmasked_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ack_i) |-> ((ack_i & $past(mask_i)) == '0));

  assert_isp_blocks_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ack_i) |-> ($past(isp_i) || ((ack_i & $past(prio_i)) == '0)));

  assert_ie_cleared_after_pushes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stack_we_i && $past(stack_we_i)) |=> !ie_i);

  assert_first_pop_loads_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stack_re_i && !$past(stack_re_i)) |-> pc_load_i);

  assert_second_pop_no_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stack_re_i && $past(stack_re_i)) |-> !pc_load_i);

  assert_load_not_with_push_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_i |-> !stack_we_i);
endmodule

bind irq_accept_ctrl irq_accept_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .boundary_i (boundary_i),
  .ack_i      (ack_o),
  .stack_we_i (stack_we_o),
  .stack_re_i (stack_re_o),
  .pc_load_i  (pc_load_o),
  .ie_i       (ie_o),
  .isp_i      (isp_o),
  .mask_i     (mask_q),
  .prio_i     (prio_q)
);

// File: tb/tb_irq_accept_ctrl.sv
module tb_irq_accept_ctrl;
  localparam int N = 8;
  localparam int PW = 16;
  localparam logic [15:0] VB = 16'h0040;
  localparam int VS = 4;
  localparam int K_NONE = 0, K_ACK = 1, K_GAP = 2, K_PSW = 3, K_PC = 4,
                 K_VLD = 5, K_POPPC = 6, K_POPPSW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0, mask_wd = '0, prio_wd = '0;
  logic mask_we = 1'b0, prio_we = 1'b0, ie_we = 1'b0, ie_wd = 1'b0;
  logic bnd = 1'b0, reti = 1'b0;
  logic [PW-1:0] pc = '0;
  logic [PW-1:0] srd;
  logic [N-1:0] ack;
  logic stack_we, stack_re, pc_load, ie, isp, busy;
  logic [PW-1:0] swd, pla;

  always #2 clk = ~clk;

  irq_accept_ctrl #(.N_SRC(N), .PC_W(PW), .VEC_BASE(VB), .VEC_STRIDE(VS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wd),
    .prio_we_i(prio_we), .prio_wdata_i(prio_wd),
    .ie_we_i(ie_we), .ie_wdata_i(ie_wd),
    .boundary_i(bnd), .reti_i(reti), .pc_i(pc), .stack_rdata_i(srd),
    .ack_o(ack), .stack_we_o(stack_we), .stack_re_o(stack_re),
    .stack_wdata_o(swd), .pc_load_o(pc_load), .pc_load_addr_o(pla),
    .ie_o(ie), .isp_o(isp), .busy_o(busy)
  );

  // bench stack with same-cycle read
  logic [PW-1:0] mem [0:63];
  logic [5:0] sp = '0;
  always @(posedge clk) begin
    if (stack_we) begin
      mem[sp] <= swd;
      sp <= sp + 6'd1;
    end else if (stack_re && sp != 6'd0) begin
      sp <= sp - 6'd1;
    end
  end
  assign srd = (sp != 6'd0) ? mem[sp - 6'd1] : '0;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  // reference model state
  bit [N-1:0] m_req = '0, m_mask = '1, m_prio = '1;
  bit m_ie = 1'b0, m_isp = 1'b1;
  int sched[$];
  int s_idx = 0;
  bit s_prio = 1'b0;
  logic [PW-1:0] s_pc = '0;

  int ack_cnt = 0, load_cyc = 0;
  logic [N-1:0] last_ack = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  task automatic cycle();
    int k;
    bit found;
    int w;
    logic [N-1:0] e_ack;
    logic e_we, e_re, e_ld;
    logic [PW-1:0] e_wd, e_la;
    #1;
    k = (sched.size() > 0) ? sched[0] : K_NONE;
    e_ack = (k == K_ACK) ? (N'(1) << s_idx) : '0;
    e_we  = (k == K_PSW) || (k == K_PC);
    e_re  = (k == K_POPPC) || (k == K_POPPSW);
    e_ld  = (k == K_VLD) || (k == K_POPPC);
    e_wd  = (k == K_PSW) ? {14'b0, m_isp, m_ie} : (k == K_PC) ? s_pc : '0;
    e_la  = (k == K_VLD) ? PW'(VB + s_idx * VS) : (k == K_POPPC) ? srd : '0;
    chk(ack == e_ack, "R4 ack", 32'(ack), 32'(e_ack));
    chk(stack_we == e_we, "R5 push", 32'(stack_we), 32'(e_we));
    chk(swd == e_wd, "R5 push data", 32'(swd), 32'(e_wd));
    chk(stack_re == e_re, "R9 pop", 32'(stack_re), 32'(e_re));
    chk(pc_load == e_ld, "R6 load", 32'(pc_load), 32'(e_ld));
    chk(pla == e_la, "R6 load addr", 32'(pla), 32'(e_la));
    chk(ie == m_ie, "R5 ie", 32'(ie), 32'(m_ie));
    chk(isp == m_isp, "R5 isp", 32'(isp), 32'(m_isp));
    chk(busy == (sched.size() > 0), "R11 busy", 32'(busy), 32'(sched.size() > 0));
    if (|ack) begin
      ack_cnt++;
      last_ack = ack;
    end
    if (pc_load && !stack_re) load_cyc = cyc;
    // model step at the coming edge
    if (sched.size() > 0) begin
      k = sched.pop_front();
      if (k == K_ACK) m_req[s_idx] = 1'b0;
      if (k == K_PC) begin
        m_ie = 1'b0;
        m_isp = s_prio;
      end
      if (k == K_POPPSW) begin
        m_ie = srd[0];
        m_isp = srd[1];
      end
    end else if (reti) begin
      sched.push_back(K_POPPC);
      sched.push_back(K_POPPSW);
    end else if (bnd && m_ie) begin
      found = 1'b0;
      w = 0;
      for (int lvl = 0; lvl < 2; lvl++) begin
        for (int i = 0; i < N; i++) begin
          if (!found && m_req[i] && !m_mask[i] && (m_prio[i] == (lvl == 1)) && (m_isp || !m_prio[i])) begin
            found = 1'b1;
            w = i;
          end
        end
      end
      if (found) begin
        s_idx = w;
        s_prio = m_prio[w];
        s_pc = pc;
        sched.push_back(K_ACK);
        if (s_prio) sched.push_back(K_GAP);
        sched.push_back(K_PSW);
        sched.push_back(K_PC);
        sched.push_back(K_GAP);
        sched.push_back(K_VLD);
      end
    end
    if (ie_we && k != K_PC && k != K_POPPSW) m_ie = ie_wd;
    m_req |= req;
    if (mask_we) m_mask = mask_wd;
    if (prio_we) m_prio = prio_wd;
    @(posedge clk);
    @(negedge clk);
    cyc++;
    req = '0; bnd = 1'b0; reti = 1'b0;
    mask_we = 1'b0; prio_we = 1'b0; ie_we = 1'b0;
    pc = 16'h1000 + 16'(cyc * 3);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic go();
    bnd = 1'b1;
    cycle();
  endtask

  task automatic ret();
    reti = 1'b1;
    cycle();
    idle(2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    int c0, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    chk(ie == 1'b0, "R12 reset ie", 32'(ie), 0);
    chk(isp == 1'b1, "R12 reset isp", 32'(isp), 1);
    chk(busy == 1'b0, "R12 reset busy", 32'(busy), 0);
    idle(2);

    // R1: masked source never taken
    prio_we = 1'b1; prio_wd = '0; ie_we = 1'b1; ie_wd = 1'b1; req = 8'h04;
    cycle();
    go(); go(); go(); idle(6);
    chk(ack_cnt == 0, "R1 masked source", 32'(ack_cnt), 0);

    // R2 / R7: pending while disabled, taken once enabled
    ie_we = 1'b1; ie_wd = 1'b0; mask_we = 1'b1; mask_wd = 8'hFB;
    cycle();
    go(); go(); idle(6);
    chk(ack_cnt == 0, "R2 enable low", 32'(ack_cnt), 0);
    ie_we = 1'b1; ie_wd = 1'b1;
    cycle();
    go(); idle(8);
    chk(ack_cnt == 1 && last_ack == 8'h04, "R7 pending taken", 32'(last_ack), 32'h04);
    ret();

    // R8: latency
    mask_we = 1'b1; mask_wd = '0;
    cycle();
    c0 = cyc; req = 8'h08; cycle(); go(); idle(8);
    chk(load_cyc - c0 + 1 == 7, "R8 high min latency", 32'(load_cyc - c0 + 1), 7);
    ret();
    prio_we = 1'b1; prio_wd = 8'h08;
    cycle();
    c0 = cyc; req = 8'h08; cycle(); go(); idle(8);
    chk(load_cyc - c0 + 1 == 8, "R8 low min latency", 32'(load_cyc - c0 + 1), 8);
    ret();
    c0 = cyc; req = 8'h08; cycle(); idle(25); go(); idle(8);
    chk(load_cyc - c0 + 1 == 33, "R8 low max latency", 32'(load_cyc - c0 + 1), 33);
    ret();
    prio_we = 1'b1; prio_wd = 8'h00;
    cycle();
    c0 = cyc; req = 8'h08; cycle(); idle(25); go(); idle(8);
    chk(load_cyc - c0 + 1 == 32, "R8 high max latency", 32'(load_cyc - c0 + 1), 32);
    ret();

    // R4: priority flag beats index, index breaks ties
    prio_we = 1'b1; prio_wd = 8'h02;
    cycle();
    req = 8'h22; cycle(); go(); idle(8);
    chk(last_ack == 8'h20, "R4 high prio wins", 32'(last_ack), 32'h20);
    ret();
    go(); idle(8);
    chk(last_ack == 8'h02, "R7 low left pending", 32'(last_ack), 32'h02);
    ret();
    req = 8'h48; cycle(); go(); idle(8);
    chk(last_ack == 8'h08, "R4 lower index wins", 32'(last_ack), 32'h08);
    ret();
    go(); idle(8);
    chk(last_ack == 8'h40, "R4 second of pair", 32'(last_ack), 32'h40);
    ret();

    // R3: in-service bit blocks low sources only
    prio_we = 1'b1; prio_wd = 8'h01;
    cycle();
    req = 8'h10; cycle(); go(); idle(8);
    chk(isp == 1'b0 && ie == 1'b0, "R5 flags after entry", 32'({isp, ie}), 0);
    ie_we = 1'b1; ie_wd = 1'b1; req = 8'h01;
    cycle();
    n = ack_cnt;
    go(); go(); go(); idle(6);
    chk(ack_cnt == n, "R3 low blocked", 32'(ack_cnt), 32'(n));
    req = 8'h80; cycle(); go(); idle(8);
    chk(last_ack == 8'h80, "R3 high nests", 32'(last_ack), 32'h80);
    ret();
    chk(ie == 1'b1 && isp == 1'b0, "R9 restore nested", 32'({isp, ie}), 32'h1);
    n = ack_cnt;
    go(); idle(6);
    chk(ack_cnt == n, "R3 still blocked", 32'(ack_cnt), 32'(n));
    ret();
    chk(ie == 1'b1 && isp == 1'b1, "R9 restore outer", 32'({isp, ie}), 32'h3);
    go(); idle(8);
    chk(last_ack == 8'h01, "R7 low after return", 32'(last_ack), 32'h01);
    ret();

    // R10: re-request in the acknowledge cycle
    prio_we = 1'b1; prio_wd = '0;
    cycle();
    req = 8'h04; cycle(); go();
    req = 8'h04; cycle();
    idle(7); ret();
    n = ack_cnt;
    go(); idle(8);
    chk(ack_cnt == n + 1 && last_ack == 8'h04, "R10 re-request kept", 32'(last_ack), 32'h04);
    ret();

    // R11: return beats boundary, strobes ignored while busy
    req = 8'h40; cycle(); go(); idle(8);
    ie_we = 1'b1; ie_wd = 1'b1; req = 8'h20;
    cycle();
    n = ack_cnt;
    reti = 1'b1; bnd = 1'b1; cycle();
    bnd = 1'b1; reti = 1'b1; cycle();
    bnd = 1'b1; cycle();
    chk(ack_cnt == n, "R11 return first", 32'(ack_cnt), 32'(n));
    chk(busy == 1'b0 && ie == 1'b1, "R11 back to idle", 32'({busy, ie}), 32'h1);
    go(); idle(8);
    chk(last_ack == 8'h20, "R11 pending after return", 32'(last_ack), 32'h20);
    ret();

    chk(sp == 6'd0, "R9 stack balanced", 32'(sp), 0);
    idle(2);
    finish_run();
  end
endmodule